// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block is a timer peripheral with several independent down-counting channels reached through a small memory-mapped register bus. Each channel has a period (reload) register, a live counter and a control register. The control register picks a clock prescaler and holds an interrupt enable and a sticky underflow flag. One shared byte-wide start register holds a run bit for every channel. Software changes one channel by read-modify-write of that byte.

While a channel runs, its counter decrements once per prescaled tick. When it passes zero it reloads from its period register and keeps counting. The same hardware therefore gives periodic events when the period is the desired interval, and nearly one-shot behaviour when the period is all ones. The complement of the counter is a rising free-running count. Every prescaled tick comes from one shared free-running divider clocked by the bus clock. Each channel drives its own level interrupt output.

Top module: `reload_timer`

## Requirements
- R1: After reset, all run bits and all control registers read 0, every period and counter register reads all ones, and every interrupt output is 0.
- R2: Address map. The start register is at 0x00, and its bits [2:0] are the run bits of channels 0..2; the bits above the channel count read 0. Channel i has its base at 0x10*(i+1). From that base, the period register is at +0, the counter at +4 and the control register at +8. Read data appears one clock after the address.
- R3: Control register layout: bits [2:0] are the prescale code, bit 5 is the interrupt enable and bit 8 is the underflow flag. All other bits read 0.
- R4: A write to the period or counter register of a stopped channel loads that register directly. A stopped counter holds its value. Counting resumes from the written counter value once the run bit is set.
- R5: A running counter decrements by one on each prescaled tick. With divisor D, a tick occurs on edge n when (n+1) mod D == 0. Here n is the number of clock edges since reset was released, counted from 0.
- R6: Prescale code 0 gives D=4, code 1 gives D=16, code 2 gives D=64, code 3 gives D=256 and code 4 gives D=1024. Codes 5, 6 and 7 give D=4.
- R7: On a tick where the counter is 0, the counter loads the period value instead of decrementing.
- R8: Every underflow sets the flag. Writing the control register with bit 8 at 0 clears the flag, and writing it with bit 8 at 1 leaves the flag unchanged. If an underflow and a clearing write happen in the same cycle, the underflow wins.
- R9: Each interrupt output is registered and equals the AND of its channel's flag and interrupt enable, updated on the same edge as those bits.
- R10: Each run bit affects only its own channel, so channels count independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data; the start register uses [7:0] and the control register uses [15:0] |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 3 | Level interrupt, one per channel |

## Verification
The bench builds the block with its defaults: three 32-bit channels and five divider stages. The shared divider runs from reset, so the bench counts clock edges since reset. For any start and stop edge it then computes arithmetically how many ticks a channel received. Small period and counter values put several underflows and reloads within a few hundred cycles. The bench sweeps all eight prescale codes, including the three unused ones, as well as the flag write cases and the per-channel run-bit isolation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFS_PERIOD = 0;
  localparam int OFS_COUNT  = 4;
  localparam int OFS_CTRL   = 8;
  localparam int PSC_W      = 3;
  localparam int IE_BIT     = 5;
  localparam int FLAG_BIT   = 8;
  localparam int CTRL_W     = 16;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [PSC_W-1:0] psc;
  } ctrl_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(ctrl_t c);
    logic [CTRL_W-1:0] r;
    r = '0;
    r[PSC_W-1:0] = c.psc;
    r[IE_BIT]    = c.ie;
    r[FLAG_BIT]  = c.flag;
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int NUM_DIV = 5
) (
  input  logic               clk,
  input  logic               rst,
  output logic [NUM_DIV-1:0] tick_o
);
  localparam int PRE_W = 2 * NUM_DIV;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
    assign tick_o[k] = &pre_q[2*k+1:0];
  end

  // R5: the fastest divisor is 4, so ticks never come on consecutive edges
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_DIV = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [NUM_DIV-1:0] tick_vec,
  input  logic               wr_period,
  input  logic               wr_count,
  input  logic               wr_ctrl,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   period_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               irq_o
);
  logic [CNT_W-1:0] period_q, count_q;
  ctrl_t            ctrl_q, ctrl_d;
  logic             tick, step, underflow;

  always_comb begin
    tick = tick_vec[0];
    for (int k = 1; k < NUM_DIV; k++)
      if (ctrl_q.psc == PSC_W'(k)) tick = tick_vec[k];
  end

  assign step      = run && tick && !wr_count;
  assign underflow = step && (count_q == '0);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.psc  = wdata[PSC_W-1:0];
      ctrl_d.ie   = wdata[IE_BIT];
      ctrl_d.flag = ctrl_q.flag & wdata[FLAG_BIT];
    end
    if (underflow) ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '1;
      count_q  <= '1;
      ctrl_q   <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_period) period_q <= wdata;
      if (wr_count)       count_q <= wdata;
      else if (underflow) count_q <= period_q;
      else if (step)      count_q <= count_q - 1'b1;
      ctrl_q <= ctrl_d;
      irq_o  <= ctrl_d.flag & ctrl_d.ie;
    end
  end

  assign period_o = period_q;
  assign count_o  = count_q;
  assign ctrl_o   = pack_ctrl(ctrl_q);

  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_count) |=> $stable(count_q));
  a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !wr_count && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !wr_count && count_q == '0) |=> count_q == $past(period_q));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.flag && !(wr_ctrl && !wdata[FLAG_BIT])) |=> ctrl_q.flag);
  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ctrl_q.flag && ctrl_q.ie));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_DIV   = 5,
  parameter int CH_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [ADDR_W-1:0] START_ADDR = '0;

  logic [NUM_CH-1:0] run_q;
  logic [NUM_DIV-1:0] ticks;
  logic [NUM_CH-1:0] wr_p, wr_c, wr_k;
  logic [CNT_W-1:0]  per_v [NUM_CH];
  logic [CNT_W-1:0]  cnt_v [NUM_CH];
  logic [CTRL_W-1:0] ctl_v [NUM_CH];
  logic [CNT_W-1:0]  rd_d;

  tmr_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(ticks));

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (bus_we && bus_addr == START_ADDR) run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int BASE = CH_STRIDE * (i + 1);
    assign wr_p[i] = bus_we && (bus_addr == ADDR_W'(BASE + OFS_PERIOD));
    assign wr_c[i] = bus_we && (bus_addr == ADDR_W'(BASE + OFS_COUNT));
    assign wr_k[i] = bus_we && (bus_addr == ADDR_W'(BASE + OFS_CTRL));

    tmr_channel #(.CNT_W(CNT_W), .NUM_DIV(NUM_DIV)) u_ch (
      .clk(clk), .rst(rst), .run(run_q[i]), .tick_vec(ticks),
      .wr_period(wr_p[i]), .wr_count(wr_c[i]), .wr_ctrl(wr_k[i]),
      .wdata(bus_wdata), .period_o(per_v[i]), .count_o(cnt_v[i]),
      .ctrl_o(ctl_v[i]), .irq_o(irq[i]));
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == START_ADDR) rd_d[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CH_STRIDE*(i+1) + OFS_PERIOD)) rd_d = per_v[i];
      if (bus_addr == ADDR_W'(CH_STRIDE*(i+1) + OFS_COUNT))  rd_d = cnt_v[i];
      if (bus_addr == ADDR_W'(CH_STRIDE*(i+1) + OFS_CTRL))   rd_d = CNT_W'(ctl_v[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  // R10: a write elsewhere never changes the run bits
  a_r10_run_isolated: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == START_ADDR) |=> $stable(run_q));
endmodule

// File: tb/sim_reload_timer.sv
`timescale 1ns/1ps
module sim_reload_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int total = 0, bad = 0;
  longint edge_n = 0;
  longint last_edge;
  logic done = 1'b0;

  reload_timer u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                   .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    last_edge = edge_n;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic longint ticks_upto(longint n, longint dv);
    return (n + 1) / dv;
  endfunction

  function automatic longint div_of(int code);
    return (code < 5) ? (longint'(4) << (2 * code)) : 4;
  endfunction

  function automatic longint model_cnt(longint c0, longint r, longint t);
    if (t <= c0) return c0 - t;
    return r - ((t - c0 - 1) % (r + 1));
  endfunction

  function automatic logic [7:0] base(int ch);
    return 8'(16 * (ch + 1));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    longint ws, we_e, t, dv;
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1, R2, R3 reset state through the bus
    rd(8'h00, v); chk("R1 start", v, 0);
    for (int c = 0; c < 3; c++) begin
      rd(base(c) + 0, v); chk("R1 period", v, 32'hFFFF_FFFF);
      rd(base(c) + 4, v); chk("R1 count", v, 32'hFFFF_FFFF);
      rd(base(c) + 8, v); chk("R1 ctrl", v, 0);
    end
    chk("R1 irq", irq, 0);

    // R4 stopped load and hold
    wr(base(1) + 4, 32'h0000_1234);
    wr(base(1) + 0, 32'h0000_0042);
    repeat (50) @(negedge clk);
    rd(base(1) + 4, v); chk("R4 count hold", v, 32'h1234);
    rd(base(1) + 0, v); chk("R4 period load", v, 32'h42);

    // R5, R6 prescale sweep on channel 0
    for (int code = 0; code < 8; code++) begin
      dv = div_of(code);
      wr(base(0) + 8, 32'(code));
      wr(base(0) + 4, 32'd100000);
      wr(8'h00, 32'h1); ws = last_edge;
      repeat (2100 + 37 * code) @(negedge clk);
      wr(8'h00, 32'h0); we_e = last_edge;
      t = ticks_upto(we_e, dv) - ticks_upto(ws, dv);
      rd(base(0) + 4, v); chk("R6 prescale count", v, 100000 - t);
      rd(base(0) + 8, v); chk("R3 ctrl psc readback", v, code);
    end

    // R7, R8, R9 underflow with interrupt on channel 1
    wr(base(1) + 0, 32'd5);
    wr(base(1) + 4, 32'd2);
    wr(base(1) + 8, 32'h20);
    wr(8'h00, 32'h2); ws = last_edge;
    repeat (60) @(negedge clk);
    wr(8'h00, 32'h0); we_e = last_edge;
    t = ticks_upto(we_e, 4) - ticks_upto(ws, 4);
    rd(base(1) + 4, v); chk("R7 reload count", v, model_cnt(2, 5, t));
    rd(base(1) + 8, v); chk("R8 flag set", v, 32'h120);
    chk("R9 irq set", irq, 3'b010);
    wr(base(1) + 8, 32'h120);
    rd(base(1) + 8, v); chk("R8 write one keeps", v, 32'h120);
    wr(base(1) + 8, 32'h100);
    rd(base(1) + 8, v); chk("R3 ie off", v, 32'h100);
    chk("R9 irq masked", irq, 3'b000);
    wr(base(1) + 8, 32'h20);
    rd(base(1) + 8, v); chk("R8 write zero clears", v, 32'h20);
    chk("R9 irq after clear", irq, 3'b000);

    // R7 periodic on channel 2, divisor 16
    wr(base(2) + 0, 32'd3);
    wr(base(2) + 4, 32'd3);
    wr(base(2) + 8, 32'h21);
    wr(8'h00, 32'h4); ws = last_edge;
    repeat (500) @(negedge clk);
    wr(8'h00, 32'h0); we_e = last_edge;
    t = ticks_upto(we_e, 16) - ticks_upto(ws, 16);
    rd(base(2) + 4, v); chk("R7 periodic count", v, model_cnt(3, 3, t));
    chk("R9 irq ch2", irq, 3'b100);

    // R10 independent run bits: run ch0 only, ch1/ch2 must hold
    wr(base(0) + 8, 32'h0);
    wr(base(0) + 4, 32'd5000);
    wr(base(1) + 4, 32'd777);
    wr(base(2) + 4, 32'd888);
    wr(8'h00, 32'h1); ws = last_edge;
    repeat (200) @(negedge clk);
    rd(8'h00, v); v = v & ~32'h1;
    wr(8'h00, v); we_e = last_edge;
    t = ticks_upto(we_e, 4) - ticks_upto(ws, 4);
    rd(base(0) + 4, v); chk("R10 ch0 ran", v, 5000 - t);
    rd(base(1) + 4, v); chk("R10 ch1 held", v, 777);
    rd(base(2) + 4, v); chk("R10 ch2 held", v, 888);

    // R2 unused start bits read 0
    wr(8'h00, 32'hFF);
    rd(8'h00, v); chk("R2 start bits", v, 32'h7);
    wr(8'h00, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule